// File: doc/BRIEF.md
# Block Write Protection Unit

This unit keeps the three protection bits of a serial memory's status register: a two-bit protection level and a hardware-lock enable bit. It also answers two questions for the command controller. The first is whether an array write to the presented address may go ahead. The second is whether a requested status register write is accepted. Serial shifting, the memory array and write-cycle timing belong to the surrounding controller. The protection bits are plain registers that reset to zero, which means no protection.

The level splits the array into quarters, counted from the top of the address space. A level of 0 leaves the whole array writable. A level of 1 locks the upper quarter, a level of 2 locks the upper half, and a level of 3 locks everything. When the write-protect pin is held low and the enable bit is 1, a hardware lock is in force. Under that lock the status register is frozen, and this includes the enable bit. Releasing the lock therefore requires raising the pin.

Every status write request that arrives with the write-enable latch set is evaluated. The unit then issues a one-cycle pulse telling the controller to clear that latch, whether the write was accepted or refused.

Top module: `bwp_unit`

## Requirements
- R1: After reset, the enable bit and the level are 0, and both the accept pulse and the latch-clear pulse are low.
- R2: At level 0 with the latch set, an array write is permitted at every address, including 0x0000 and 0x3FFF.
- R3: At level 1 (14-bit address), addresses 0x3000 to 0x3FFF are refused and 0x0000 to 0x2FFF are permitted.
- R4: At level 2, addresses 0x2000 to 0x3FFF are refused and 0x0000 to 0x1FFF are permitted.
- R5: At level 3, no array write is permitted at any address.
- R6: While the write-enable latch input is low, no array write is permitted, whatever the level or address.
- R7: A status write request with the latch set and no hardware lock is accepted. The data field uses bit 2 for the enable bit and bits 1:0 for the level. The bits take that data on the clock edge that samples the request, and the accept output is high for exactly the following cycle.
- R8: A status write request with the latch clear is ignored. The bits are unchanged, and neither the accept pulse nor the latch-clear pulse is raised. Without a request, the bits never change.
- R9: The hardware lock is active when the pin is low and the enable bit is 1. Under the lock, a status write request with the latch set is refused: the bits are unchanged and no accept pulse is raised. Array protection keeps following the stored level.
- R10: With the pin high, a status write is accepted even when the enable bit is 1, including a write that clears the enable bit.
- R11: Every status write request made with the latch set, whether accepted or refused, produces a latch-clear pulse lasting exactly one cycle.
- R12: While the pin stays low, an enable bit of 1 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin; low arms the hardware lock |
| wel_i | input | 1 | Write-enable latch state from the controller |
| sr_wr_req_i | input | 1 | Status write request, one cycle |
| sr_wr_data_i | input | 3 | Status write data: bit 2 enable, bits 1:0 level |
| arr_addr_i | input | ADDR_W (14) | Array write address under test |
| wpen_o | output | 1 | Stored hardware-lock enable bit |
| level_o | output | 2 | Stored protection level |
| sr_wr_ack_o | output | 1 | One-cycle pulse: status write accepted |
| wel_clr_o | output | 1 | One-cycle pulse: controller must clear its latch |
| arr_wr_ok_o | output | 1 | Array write permitted for arr_addr_i |

## Verification
On every cycle, the checker confirms several rules. Locked writes must leave the bits frozen with no accept pulse. Unlocked writes must load their data. Requests made without the latch must change nothing. An enable bit of 1 must persist while the pin is low. Each evaluated request must produce a clear pulse. Level 3 and a clear latch must always block array writes. Only the bench's scenarios demonstrate the exact quarter boundaries at each level, the reset values, the unlock sequence that raises the pin and then clears the enable bit, and the fact that both pulses last a single cycle.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
    localparam int LEVEL_W  = 2;
    localparam int STATUS_W = LEVEL_W + 1;

    typedef struct packed {
        logic               wpen;
        logic [LEVEL_W-1:0] level;
    } prot_bits_t;
endpackage

// File: rtl/bwp_lock.sv
module bwp_lock (
    input  logic wp_n_i,
    input  logic wpen_i,
    output logic lock_o
);
    // Hardware lock: pin driven low while the enable bit is set.
    always_comb begin
        lock_o = ~wp_n_i & wpen_i;
    end
endmodule

// File: rtl/bwp_range.sv
module bwp_range #(
    parameter int ADDR_W = 14
) (
    input  logic [1:0]        level_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);
    localparam int TOP = ADDR_W - 1;

    logic in_top_half;
    logic in_top_quarter;

    always_comb begin
        in_top_half    = addr_i[TOP];
        in_top_quarter = addr_i[TOP] & addr_i[TOP-1];
        unique case (level_i)
            2'd0:    prot_o = 1'b0;
            2'd1:    prot_o = in_top_quarter;
            2'd2:    prot_o = in_top_half;
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/bwp_status_reg.sv
module bwp_status_reg
    import bwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       wel_i,
    input  logic       lock_i,
    input  prot_bits_t data_i,
    output prot_bits_t bits_o,
    output logic       ack_o,
    output logic       clr_o
);
    typedef struct packed {
        prot_bits_t bits;
        logic       ack;
        logic       clr;
    } sreg_t;

    sreg_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        st_d.clr = 1'b0;
        if (req_i && wel_i) begin
            st_d.clr = 1'b1;
            if (!lock_i) begin
                st_d.bits = data_i;
                st_d.ack  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;
    assign ack_o  = st_q.ack;
    assign clr_o  = st_q.clr;
endmodule

// File: rtl/bwp_unit.sv
module bwp_unit
    import bwp_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              wel_i,
    input  logic              sr_wr_req_i,
    input  logic [2:0]        sr_wr_data_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    output logic              wpen_o,
    output logic [1:0]        level_o,
    output logic              sr_wr_ack_o,
    output logic              wel_clr_o,
    output logic              arr_wr_ok_o
);
    prot_bits_t bits_q;
    prot_bits_t wr_data;
    logic       hw_lock;
    logic       addr_prot;

    assign wr_data = prot_bits_t'(sr_wr_data_i);

    bwp_lock u_lock (
        .wp_n_i (wp_n_i),
        .wpen_i (bits_q.wpen),
        .lock_o (hw_lock)
    );

    bwp_status_reg u_sreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (sr_wr_req_i),
        .wel_i  (wel_i),
        .lock_i (hw_lock),
        .data_i (wr_data),
        .bits_o (bits_q),
        .ack_o  (sr_wr_ack_o),
        .clr_o  (wel_clr_o)
    );

    bwp_range #(.ADDR_W(ADDR_W)) u_range (
        .level_i (bits_q.level),
        .addr_i  (arr_addr_i),
        .prot_o  (addr_prot)
    );

    assign wpen_o      = bits_q.wpen;
    assign level_o     = bits_q.level;
    assign arr_wr_ok_o = wel_i & ~addr_prot;
endmodule

// File: rtl/bwp_unit_chk.sv
module bwp_unit_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n_i,
    input logic              wel_i,
    input logic              sr_wr_req_i,
    input logic [2:0]        sr_wr_data_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic              wpen_o,
    input logic [1:0]        level_o,
    input logic              sr_wr_ack_o,
    input logic              wel_clr_o,
    input logic              arr_wr_ok_o
);
    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req_i && wel_i && !(!wp_n_i && wpen_o))
        |=> (sr_wr_ack_o && {wpen_o, level_o} == $past(sr_wr_data_i)));

    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req_i && !wel_i)
        |=> (!sr_wr_ack_o && !wel_clr_o && $stable({wpen_o, level_o})));

    assert_no_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_req_i |=> $stable({wpen_o, level_o}));

    assert_locked_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req_i && !wp_n_i && wpen_o)
        |=> (!sr_wr_ack_o && $stable({wpen_o, level_o})));

    assert_clear_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req_i && wel_i) |=> wel_clr_o);

    assert_ack_has_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_ack_o |-> wel_clr_o);

    assert_wpen_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wpen_o && !wp_n_i) |=> wpen_o);

    assert_full_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 2'd3) |-> !arr_wr_ok_o);

    assert_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_i |-> !arr_wr_ok_o);

    assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 2'd0 && wel_i) |-> arr_wr_ok_o);
endmodule

bind bwp_unit bwp_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_n_i       (wp_n_i),
    .wel_i        (wel_i),
    .sr_wr_req_i  (sr_wr_req_i),
    .sr_wr_data_i (sr_wr_data_i),
    .arr_addr_i   (arr_addr_i),
    .wpen_o       (wpen_o),
    .level_o      (level_o),
    .sr_wr_ack_o  (sr_wr_ack_o),
    .wel_clr_o    (wel_clr_o),
    .arr_wr_ok_o  (arr_wr_ok_o)
);

// File: tb/sim_bwp_unit.sv
`timescale 1ns/1ps
module sim_bwp_unit;
    localparam int AW = 14;
    localparam int NV = 13;
    // {level[1:0], wel, addr[13:0], expected ok}
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 1'b1, 14'h0000, 1'b1},
        {2'd0, 1'b1, 14'h3FFF, 1'b1},
        {2'd0, 1'b0, 14'h1234, 1'b0},
        {2'd1, 1'b1, 14'h2FFF, 1'b1},
        {2'd1, 1'b1, 14'h3000, 1'b0},
        {2'd1, 1'b1, 14'h3FFF, 1'b0},
        {2'd1, 1'b0, 14'h0000, 1'b0},
        {2'd2, 1'b1, 14'h1FFF, 1'b1},
        {2'd2, 1'b1, 14'h2000, 1'b0},
        {2'd2, 1'b1, 14'h0000, 1'b1},
        {2'd3, 1'b1, 14'h0000, 1'b0},
        {2'd3, 1'b1, 14'h3FFF, 1'b0},
        {2'd3, 1'b1, 14'h1FFF, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n_i = 1'b1;
    logic          wel_i = 1'b0;
    logic          sr_wr_req_i = 1'b0;
    logic [2:0]    sr_wr_data_i = '0;
    logic [AW-1:0] arr_addr_i = '0;
    logic          wpen_o;
    logic [1:0]    level_o;
    logic          sr_wr_ack_o;
    logic          wel_clr_o;
    logic          arr_wr_ok_o;

    int checks = 0;
    int errors = 0;
    logic got_ack, got_clr, ack_after, clr_after;

    always #5 clk = ~clk;

    bwp_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i), .wel_i(wel_i),
        .sr_wr_req_i(sr_wr_req_i), .sr_wr_data_i(sr_wr_data_i),
        .arr_addr_i(arr_addr_i), .wpen_o(wpen_o), .level_o(level_o),
        .sr_wr_ack_o(sr_wr_ack_o), .wel_clr_o(wel_clr_o),
        .arr_wr_ok_o(arr_wr_ok_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issues one status write; captures both pulses in the cycle after and the one after that.
    task automatic sr_write(input logic [2:0] data, input logic wel);
        @(negedge clk);
        sr_wr_req_i  = 1'b1;
        sr_wr_data_i = data;
        wel_i        = wel;
        @(negedge clk);
        got_ack      = sr_wr_ack_o;
        got_clr      = wel_clr_o;
        sr_wr_req_i  = 1'b0;
        wel_i        = 1'b0;
        @(negedge clk);
        ack_after    = sr_wr_ack_o;
        clr_after    = wel_clr_o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 level", {30'd0, level_o}, 32'd0);
        chk("R1 wpen", {31'd0, wpen_o}, 32'd0);
        chk("R1 pulses", {30'd0, sr_wr_ack_o, wel_clr_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {28'd0, wpen_o, level_o, sr_wr_ack_o}, 32'd0);

        // Vector table: range decoding per level.
        for (int i = 0; i < NV; i++) begin
            logic [1:0] lvl;
            string      tag;
            lvl = VEC[i][17:16];
            if (level_o != lvl) begin
                sr_write({1'b0, lvl}, 1'b1);
                chk("R7 level load ack", {31'd0, got_ack}, 32'd1);
                chk("R7 level value", {30'd0, level_o}, {30'd0, lvl});
            end
            @(negedge clk);
            wel_i      = VEC[i][15];
            arr_addr_i = VEC[i][14:1];
            #1;
            if (!VEC[i][15])     tag = "R6 latch clear";
            else if (lvl == 2'd0) tag = "R2 level0";
            else if (lvl == 2'd1) tag = "R3 level1";
            else if (lvl == 2'd2) tag = "R4 level2";
            else                  tag = "R5 level3";
            chk(tag, {31'd0, arr_wr_ok_o}, {31'd0, VEC[i][0]});
            wel_i = 1'b0;
        end

        // R8: request without latch is ignored.
        sr_write(3'b000, 1'b1);
        sr_write(3'b111, 1'b0);
        chk("R8 bits unchanged", {29'd0, wpen_o, level_o}, 32'd0);
        chk("R8 no ack", {31'd0, got_ack}, 32'd0);
        chk("R8 no clear", {31'd0, got_clr}, 32'd0);

        // R7 / R11: accepted write, pulses last one cycle.
        sr_write(3'b001, 1'b1);
        chk("R7 ack", {31'd0, got_ack}, 32'd1);
        chk("R7 ack one cycle", {31'd0, ack_after}, 32'd0);
        chk("R11 clear pulse", {31'd0, got_clr}, 32'd1);
        chk("R11 clear one cycle", {31'd0, clr_after}, 32'd0);
        chk("R7 bits", {29'd0, wpen_o, level_o}, 32'd1);

        // R10: pin high, enable set then cleared.
        sr_write(3'b110, 1'b1);
        chk("R10 set enable", {29'd0, wpen_o, level_o}, 32'h6);
        sr_write(3'b000, 1'b1);
        chk("R10 clear enable ack", {31'd0, got_ack}, 32'd1);
        chk("R10 clear enable bits", {29'd0, wpen_o, level_o}, 32'd0);

        // R9 / R11 / R12: locked.
        sr_write(3'b110, 1'b1);
        @(negedge clk);
        wp_n_i = 1'b0;
        sr_write(3'b000, 1'b1);
        chk("R9 refused ack", {31'd0, got_ack}, 32'd0);
        chk("R11 refused clear", {31'd0, got_clr}, 32'd1);
        chk("R9 bits frozen", {29'd0, wpen_o, level_o}, 32'h6);
        sr_write(3'b011, 1'b1);
        chk("R9 level frozen", {29'd0, wpen_o, level_o}, 32'h6);
        @(negedge clk);
        wel_i      = 1'b1;
        arr_addr_i = 14'h2000;
        #1;
        chk("R9 array still protected", {31'd0, arr_wr_ok_o}, 32'd0);
        arr_addr_i = 14'h1FFF;
        #1;
        chk("R9 array low half open", {31'd0, arr_wr_ok_o}, 32'd1);
        wel_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 enable held", {31'd0, wpen_o}, 32'd1);

        // Unlock by raising the pin.
        wp_n_i = 1'b1;
        sr_write(3'b000, 1'b1);
        chk("R10 unlock ack", {31'd0, got_ack}, 32'd1);
        chk("R10 unlock bits", {29'd0, wpen_o, level_o}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule